// File: doc/BRIEF.md
# I2C Interrupt Request Flag Generator

This block raises the one interrupt request flag of an I2C controller. The bit-level engine reports bus events to it as single-cycle strobes. These events are start and stop detection, SCL edges tagged with the clock number within the frame, the sampled acknowledge bit, arbitration loss, own-address match and general call detection. The block merges these strobes with a handful of configuration levels. Each qualifying event sets a sticky flag, which the CPU clears through its register interface.

The transfer-end set point depends on configuration. In master mode it falls on the 8th SCL falling edge when wait insertion is enabled, and otherwise on the 9th SCL rising edge. In slave mode, transfer ends raise the flag only inside an addressed window. A match on the own address, or a general call with R/W = 0, opens this window. A repeated start or a stop closes it. Every flag set is registered, so the flag reads 1 in the cycle after the strobe that causes it.

Top module: `i2c_irq_flag`

## Requirements
- R1: After reset the flag is 0 and the addressed window is closed, so a 9th SCL rising edge in slave mode does not set the flag.
- R2: In master mode, a start strobe sets the flag only if a start command was issued since the last start strobe. A start strobe with no command pending leaves the flag at 0.
- R3: In master mode with wait insertion enabled, an SCL falling strobe with clock number 8 sets the flag. An SCL rising strobe with clock number 9 does not.
- R4: In master mode with wait insertion disabled, an SCL rising strobe with clock number 9 sets the flag. A falling strobe with number 8 does not, and neither does a rising strobe with number 8.
- R5: An arbitration-loss strobe sets the flag when the arbitration-loss interrupt enable is 1, and has no direct effect when the enable is 0.
- R6: After an arbitration loss, the 9th-clock rising edge of the first frame that follows a start strobe sets the flag, whatever the mode and enables. The pending loss is then dropped, so later frames in slave mode do not set the flag through this path.
- R7: An acknowledge strobe with a sampled value of 1 (NACK) sets the flag when acknowledge checking is 1. An acknowledge value of 0, or checking set to 0, has no effect.
- R8: In slave mode, an own-address match strobe sets the flag and opens the addressed window. Inside the window, every 9th-clock rising edge sets the flag, and an 8th-clock falling edge does not.
- R9: In slave mode, a general call strobe with R/W = 0 sets the flag and opens the window. With R/W = 1 it does neither.
- R10: A start strobe or a stop strobe closes the window, and a later 9th-clock rising edge in slave mode leaves the flag at 0.
- R11: A stop strobe sets the flag when the stop mask is 0, and has no effect when the mask is 1.
- R12: The flag stays 1 until the CPU clears it. A CPU write with data bit 0 clears it only if a CPU read has seen the flag at 1 since the last CPU write. Writes with data bit 1 never clear it, and every write disarms the clear.
- R13: If a set condition and a valid clear fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_wait_en | input | 1 | Wait insertion enable between the data bits and the acknowledge bit |
| cfg_ack_chk | input | 1 | Raise the flag on a received NACK |
| cfg_al_ie | input | 1 | Arbitration-loss interrupt enable |
| cfg_stop_mask | input | 1 | 1 suppresses the stop-detect source |
| cmd_start | input | 1 | Strobe: the controller issued a start |
| ev_start | input | 1 | Strobe: start or repeated start seen on the bus |
| ev_stop | input | 1 | Strobe: stop seen on the bus |
| ev_scl_fall | input | 1 | Strobe: SCL falling edge |
| ev_scl_rise | input | 1 | Strobe: SCL rising edge |
| bit_cnt | input | CNT_W | Clock number (1 to 9) within the frame, valid with the SCL strobes |
| ev_ack_rx | input | 1 | Strobe: acknowledge bit sampled |
| ack_val | input | 1 | Sampled acknowledge value (1 = NACK) |
| ev_arb_lost | input | 1 | Strobe: arbitration lost |
| ev_addr_match | input | 1 | Strobe: own slave address matched |
| ev_gcall | input | 1 | Strobe: general call address received |
| gc_rw | input | 1 | R/W bit received with the general call |
| cpu_rd | input | 1 | CPU read of the flag register |
| cpu_wr | input | 1 | CPU write of the flag register |
| cpu_wdata | input | 1 | Data bit written by the CPU |
| irq_flag | output | 1 | Interrupt request flag |

## Verification
Assertions check several rules on every cycle. A set flag holds unless a write with data bit 0 arrives. A write with data bit 1 never clears it. A falling flag always follows such a write. The stop, NACK and enabled arbitration-loss sources always set the flag one cycle later. The stateful paths depend on event history: the issued-start pairing, the first frame after an arbitration loss, and the opening and closing of the addressed window. The bench scenarios show these paths, along with the read-then-write clear handshake and its collision with a set. A random phase compares the flag with an independent model over long mixed event streams.

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag #(
  parameter int CNT_W    = 4,
  parameter int WAIT_CLK = 8,
  parameter int ACK_CLK  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_wait_en,
  input  logic             cfg_ack_chk,
  input  logic             cfg_al_ie,
  input  logic             cfg_stop_mask,
  input  logic             cmd_start,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_scl_fall,
  input  logic             ev_scl_rise,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             ev_ack_rx,
  input  logic             ack_val,
  input  logic             ev_arb_lost,
  input  logic             ev_addr_match,
  input  logic             ev_gcall,
  input  logic             gc_rw,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic             cpu_wdata,
  output logic             irq_flag
);
  localparam logic [CNT_W-1:0] WAIT_N = CNT_W'(WAIT_CLK);
  localparam logic [CNT_W-1:0] ACK_N  = CNT_W'(ACK_CLK);

  logic start_pend, al_pend, first_frm, addr_win, rd_armed;

  wire clk8_fall = ev_scl_fall && (bit_cnt == WAIT_N);
  wire clk9_rise = ev_scl_rise && (bit_cnt == ACK_N);
  wire win_open  = !cfg_master && (ev_addr_match || (ev_gcall && !gc_rw));
  wire win_close = ev_start || ev_stop;

  wire s_mstart = cfg_master && start_pend && ev_start;
  wire s_mxfer  = cfg_master && (cfg_wait_en ? clk8_fall : clk9_rise);
  wire s_alfrm  = al_pend && first_frm && clk9_rise;
  wire s_nack   = ev_ack_rx && ack_val && cfg_ack_chk;
  wire s_al     = ev_arb_lost && cfg_al_ie;
  wire s_slave  = win_open || (!cfg_master && addr_win && clk9_rise);
  wire s_stop   = ev_stop && !cfg_stop_mask;

  wire any_set  = s_mstart | s_mxfer | s_alfrm | s_nack | s_al | s_slave | s_stop;
  wire cpu_clr  = cpu_wr && !cpu_wdata && rd_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag   <= 1'b0;
      start_pend <= 1'b0;
      al_pend    <= 1'b0;
      first_frm  <= 1'b0;
      addr_win   <= 1'b0;
      rd_armed   <= 1'b0;
    end else begin
      irq_flag <= any_set | (irq_flag & ~cpu_clr);

      if (ev_start)       start_pend <= 1'b0;
      else if (cmd_start) start_pend <= 1'b1;

      if (ev_start)       first_frm <= 1'b1;
      else if (clk9_rise) first_frm <= 1'b0;

      if (ev_arb_lost)              al_pend <= 1'b1;
      else if (s_alfrm || ev_stop)  al_pend <= 1'b0;

      if (win_open)       addr_win <= 1'b1;
      else if (win_close) addr_win <= 1'b0;

      if (cpu_wr)                 rd_armed <= 1'b0;
      else if (cpu_rd && irq_flag) rd_armed <= 1'b1;
    end
  end
endmodule

module i2c_irq_flag_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_ack_chk,
  input logic cfg_al_ie,
  input logic cfg_stop_mask,
  input logic ev_stop,
  input logic ev_ack_rx,
  input logic ack_val,
  input logic ev_arb_lost,
  input logic cpu_wr,
  input logic cpu_wdata,
  input logic irq_flag
);
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !cpu_wr |=> irq_flag); // R12
  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && cpu_wr && cpu_wdata |=> irq_flag); // R12
  AST_FALL_AFTER_WRITE0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(cpu_wr && !cpu_wdata)); // R12
  AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && !cfg_stop_mask |=> irq_flag); // R11
  AST_NACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_rx && ack_val && cfg_ack_chk |=> irq_flag); // R7
  AST_ARB_LOST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost && cfg_al_ie |=> irq_flag); // R5
endmodule

bind i2c_irq_flag i2c_irq_flag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ack_chk(cfg_ack_chk), .cfg_al_ie(cfg_al_ie),
  .cfg_stop_mask(cfg_stop_mask), .ev_stop(ev_stop), .ev_ack_rx(ev_ack_rx),
  .ack_val(ack_val), .ev_arb_lost(ev_arb_lost), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .irq_flag(irq_flag)
);

// File: tb/sim_i2c_irq_flag.sv
module sim_i2c_irq_flag;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master, cfg_wait_en, cfg_ack_chk, cfg_al_ie, cfg_stop_mask;
  logic cmd_start, ev_start, ev_stop, ev_scl_fall, ev_scl_rise;
  logic [3:0] bit_cnt;
  logic ev_ack_rx, ack_val, ev_arb_lost, ev_addr_match, ev_gcall, gc_rw;
  logic cpu_rd, cpu_wr, cpu_wdata, irq_flag;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  // reference model state
  bit m_flag, m_sp, m_al, m_ff, m_win, m_arm;

  always #10 clk = ~clk;

  i2c_irq_flag u0 (.*);

  task automatic idle();
    cmd_start = 0; ev_start = 0; ev_stop = 0; ev_scl_fall = 0; ev_scl_rise = 0;
    bit_cnt = 0; ev_ack_rx = 0; ack_val = 0; ev_arb_lost = 0; ev_addr_match = 0;
    ev_gcall = 0; gc_rw = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
  endtask

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: irq_flag=%0b expected %0b", tag, got, exp);
    end
  endtask

  function automatic bit model_set();
    bit r9 = ev_scl_rise && bit_cnt == 9;
    bit f8 = ev_scl_fall && bit_cnt == 8;
    bit hit = 0;
    if (cfg_master && ev_start && m_sp) hit = 1;
    if (cfg_master && !cfg_wait_en && r9) hit = 1;
    if (cfg_master && cfg_wait_en && f8) hit = 1;
    if (m_al && m_ff && r9) hit = 1;
    if (cfg_ack_chk && ev_ack_rx && ack_val) hit = 1;
    if (cfg_al_ie && ev_arb_lost) hit = 1;
    if (!cfg_master && (ev_addr_match || (ev_gcall && !gc_rw))) hit = 1;
    if (!cfg_master && m_win && r9) hit = 1;
    if (!cfg_stop_mask && ev_stop) hit = 1;
    return hit;
  endfunction

  task automatic model_step();
    bit r9 = ev_scl_rise && bit_cnt == 9;
    bit opn = !cfg_master && (ev_addr_match || (ev_gcall && !gc_rw));
    bit alf = m_al && m_ff && r9;
    bit s = model_set();
    bit clr = cpu_wr && !cpu_wdata && m_arm;
    bit nf = s || (m_flag && !clr);
    m_arm = cpu_wr ? 1'b0 : (m_arm || (cpu_rd && m_flag));
    m_flag = nf;
    m_sp = ev_start ? 1'b0 : (m_sp || cmd_start);
    m_ff = ev_start ? 1'b1 : (r9 ? 1'b0 : m_ff);
    m_al = ev_arb_lost ? 1'b1 : ((alf || ev_stop) ? 1'b0 : m_al);
    m_win = opn ? 1'b1 : ((ev_start || ev_stop) ? 1'b0 : m_win);
  endtask

  // drive at negedge is already done by caller; advance one cycle and return at next negedge
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic expect_after(input bit exp, input string tag);
    tick();
    check(irq_flag, exp, tag);
  endtask

  task automatic cpu_clear();
    cpu_rd = 1; tick();
    cpu_wr = 1; cpu_wdata = 0; tick();
  endtask

  task automatic edge_ev(input bit rise, input int n);
    if (rise) ev_scl_rise = 1; else ev_scl_fall = 1;
    bit_cnt = 4'(n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: irq_flag=%0b expected run end", irq_flag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    cfg_master = 1; cfg_wait_en = 0; cfg_ack_chk = 0; cfg_al_ie = 0; cfg_stop_mask = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(irq_flag, 0, "R1 reset");

    // R2 master start pairing
    ev_start = 1; expect_after(0, "R2 start without command");
    cmd_start = 1; tick();
    ev_start = 1; expect_after(1, "R2 issued start seen");
    cpu_clear(); check(irq_flag, 0, "R12 clear");

    // R3 wait mode
    cfg_wait_en = 1;
    edge_ev(1, 9); expect_after(0, "R3 no set on 9th rise");
    edge_ev(0, 8); expect_after(1, "R3 set on 8th fall");
    cpu_clear();

    // R4 no-wait mode
    cfg_wait_en = 0;
    edge_ev(0, 8); expect_after(0, "R4 no set on 8th fall");
    edge_ev(1, 8); expect_after(0, "R4 no set on 8th rise");
    edge_ev(1, 9); expect_after(1, "R4 set on 9th rise");
    cpu_clear();

    // R5 arbitration loss
    ev_arb_lost = 1; expect_after(0, "R5 loss with enable 0");
    cfg_al_ie = 1;
    ev_arb_lost = 1; expect_after(1, "R5 loss with enable 1");
    cpu_clear();
    cfg_al_ie = 0; cfg_master = 0;

    // R6 first frame after loss
    ev_start = 1; expect_after(0, "R6 start in slave");
    edge_ev(1, 9); expect_after(1, "R6 first frame end");
    cpu_clear();
    edge_ev(1, 9); expect_after(0, "R6 later frame");

    // R7 NACK
    cfg_ack_chk = 1;
    ev_ack_rx = 1; ack_val = 0; expect_after(0, "R7 ACK 0");
    ev_ack_rx = 1; ack_val = 1; expect_after(1, "R7 NACK");
    cpu_clear();
    cfg_ack_chk = 0;
    ev_ack_rx = 1; ack_val = 1; expect_after(0, "R7 check off");

    // R8 own address window
    edge_ev(1, 9); expect_after(0, "R8 outside window");
    ev_addr_match = 1; expect_after(1, "R8 match");
    cpu_clear();
    edge_ev(1, 9); expect_after(1, "R8 9th rise in window");
    cpu_clear();
    edge_ev(0, 8); expect_after(0, "R8 8th fall in window");

    // R10 close on start
    ev_start = 1; expect_after(0, "R10 repeated start");
    edge_ev(1, 9); expect_after(0, "R10 after start");

    // R9 general call
    ev_gcall = 1; gc_rw = 1; expect_after(0, "R9 gcall rw 1");
    edge_ev(1, 9); expect_after(0, "R9 no window rw 1");
    ev_gcall = 1; gc_rw = 0; expect_after(1, "R9 gcall rw 0");
    cpu_clear();
    edge_ev(1, 9); expect_after(1, "R9 window byte");
    cpu_clear();
    ev_stop = 1; expect_after(0, "R11 stop masked");
    edge_ev(1, 9); expect_after(0, "R10 after stop");

    // R11 stop unmasked
    cfg_stop_mask = 0;
    ev_stop = 1; expect_after(1, "R11 stop");

    // R12 clear handshake
    cpu_wr = 1; cpu_wdata = 0; expect_after(1, "R12 write 0 without read");
    cpu_rd = 1; tick();
    cpu_wr = 1; cpu_wdata = 1; expect_after(1, "R12 write 1");
    cpu_wr = 1; cpu_wdata = 0; expect_after(1, "R12 disarmed by write");
    cpu_rd = 1; tick();
    cpu_wr = 1; cpu_wdata = 0; expect_after(0, "R12 read then write 0");

    // R13 collision
    ev_stop = 1; tick();
    cpu_rd = 1; tick();
    cpu_wr = 1; cpu_wdata = 0; ev_stop = 1; expect_after(1, "R13 set wins");

    // random phase against model
    rst_n = 0; tick(); rst_n = 1;
    m_flag = 0; m_sp = 0; m_al = 0; m_ff = 0; m_win = 0; m_arm = 0;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 31) == 0) begin
        cfg_master = 1'($urandom); cfg_wait_en = 1'($urandom); cfg_ack_chk = 1'($urandom);
        cfg_al_ie = 1'($urandom); cfg_stop_mask = 1'($urandom);
      end
      cmd_start = $urandom_range(0, 15) == 0;
      ev_start = $urandom_range(0, 15) == 0;
      ev_stop = $urandom_range(0, 23) == 0;
      ev_scl_rise = $urandom_range(0, 3) == 0;
      ev_scl_fall = !ev_scl_rise && $urandom_range(0, 3) == 0;
      bit_cnt = 4'($urandom_range(1, 9));
      ev_ack_rx = $urandom_range(0, 9) == 0; ack_val = 1'($urandom);
      ev_arb_lost = $urandom_range(0, 29) == 0;
      ev_addr_match = $urandom_range(0, 19) == 0;
      ev_gcall = $urandom_range(0, 19) == 0; gc_rw = 1'($urandom);
      cpu_rd = $urandom_range(0, 3) == 0;
      cpu_wr = $urandom_range(0, 4) == 0; cpu_wdata = $urandom_range(0, 3) == 0;
      model_step();
      expect_after(m_flag, "random vs model");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule